// File: doc/BRIEF.md
# Indexed Store Queue Forwarding

This block holds the stores that are in flight between allocation and commit, and supplies store data to loads without an address search over the whole queue. A load arrives with the queue slot that a dependence predictor named for it. The block reads only that one slot and makes one address compare. A live slot whose address matches and whose data is present forwards its data. In every other case the load is told to take its value from the data cache.

Stores enter at the tail in program order. Their addresses and data are written later, by slot index, as the store executes. Stores leave from the head at commit. A load marked difficult is held until the store in its predicted slot is the oldest one left, so every older candidate has committed. A load whose slot matches but has no data yet is held until the data is written. Before the load commits, a filter compares the value it used with a recomputed correct value and raises a flush for one cycle when the two differ.

Top module: `sq_idx_fwd`

## Requirements
- R1: A store allocation takes the slot shown on `st_alloc_idx` (the tail), and slots are handed out in increasing index order, wrapping modulo DEPTH. While the queue holds DEPTH stores, `sq_full` is 1 and an allocation request is ignored.
- R2: A commit frees the slot at the head. A commit on an empty queue is ignored.
- R3: A load whose predicted slot is live, has a written address equal to the load address and has written data gets `ld_resp_fwd`=1 and that slot's data on `ld_resp_data`.
- R4: A load whose live predicted slot has no written address, or a different address, gets `ld_resp_fwd`=0 (cache path), and only the predicted slot is consulted.
- R5: A predicted index outside the live region between head and tail gives the cache path, even when the stale slot still holds a matching address.
- R6: A load whose predicted slot matches but has no data yet is held (`ld_ready`=0, no response) until the data is written, and it then forwards. It never falls through to the cache.
- R7: A load with `ld_delay`=1 is held while its predicted slot is live and is not at the head. Once the head reaches that slot, it performs the normal lookup.
- R8: `flush` is 1 in the cycle after a `chk_valid` cycle in which `chk_used_data` differs from `chk_ref_data`, and it is 0 after a matching check or when there is no check.
- R9: After reset the queue is empty: `sq_full`=0, `st_alloc_idx`=0, `ld_ready`=1, `ld_resp_valid`=0 and `flush`=0.
- R10: A load is accepted on a clock edge where `ld_req_valid` and `ld_ready` are both 1. If it can be resolved, `ld_resp_valid` is 1 for exactly one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_alloc | input | 1 | Allocate a store slot at the tail |
| st_alloc_idx | output | IW | Slot that the next allocation takes |
| sq_full | output | 1 | Queue holds DEPTH stores |
| st_addr_we | input | 1 | Write a store address |
| st_addr_idx | input | IW | Slot for the address write |
| st_addr | input | AW | Store address |
| st_data_we | input | 1 | Write store data |
| st_data_idx | input | IW | Slot for the data write |
| st_data | input | DW | Store data |
| st_commit | input | 1 | Retire the store at the head |
| ld_req_valid | input | 1 | Load lookup request |
| ld_ready | output | 1 | Port can accept a load |
| ld_addr | input | AW | Load address |
| ld_pred_idx | input | IW | Predicted store slot |
| ld_delay | input | 1 | Hold the load until its slot reaches the head |
| ld_resp_valid | output | 1 | Lookup result is valid |
| ld_resp_fwd | output | 1 | 1: data from the queue, 0: use the data cache |
| ld_resp_data | output | DW | Forwarded data |
| chk_valid | input | 1 | Commit-time check request |
| chk_used_data | input | DW | Value the load consumed |
| chk_ref_data | input | DW | Recomputed correct value |
| flush | output | 1 | Misforward detected, flush the pipeline |

## Verification
The bench builds the block with DEPTH=4, AW=16 and DW=32. With four slots, a few allocations are enough to reach a full queue, wrap the tail and leave committed slots behind that still hold matching addresses. Each load result is compared with a reference that searches every live store associatively for the youngest matching one. That reference value is then fed back through the commit check, so deliberate mispredictions must raise a flush and correct forwards must not.

// File: rtl/sq_idx_pkg.sv
package sq_idx_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_FWD   = 2'd2,
    ACT_CACHE = 2'd3
  } lk_act_e;
endpackage

// File: rtl/sq_entry_array.sv
module sq_entry_array #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_we,
  input  logic [IW-1:0] clr_idx,
  input  logic          aw_we,
  input  logic [IW-1:0] aw_idx,
  input  logic [AW-1:0] aw_addr,
  input  logic          dw_we,
  input  logic [IW-1:0] dw_idx,
  input  logic [DW-1:0] dw_data,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_addr_vld,
  output logic [AW-1:0] rd_addr,
  output logic          rd_data_vld,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [DEPTH-1:0] addr_vld;
  logic [DEPTH-1:0] data_vld;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (aw_we) addr_mem[aw_idx] <= aw_addr;
    if (dw_we) data_mem[dw_idx] <= dw_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flags
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_vld[g] <= 1'b0;
        data_vld[g] <= 1'b0;
      end else begin
        if (clr_we && clr_idx == IW'(g)) begin
          addr_vld[g] <= 1'b0;
          data_vld[g] <= 1'b0;
        end
        if (aw_we && aw_idx == IW'(g)) addr_vld[g] <= 1'b1;
        if (dw_we && dw_idx == IW'(g)) data_vld[g] <= 1'b1;
      end
    end
  end

  // one indexed read, no search
  assign rd_addr_vld = addr_vld[rd_idx];
  assign rd_addr     = addr_mem[rd_idx];
  assign rd_data_vld = data_vld[rd_idx];
  assign rd_data     = data_mem[rd_idx];

  // R1: a freshly allocated slot starts without address or data
  a_r1_clear_on_alloc: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !aw_we && !dw_we) |=> (!addr_vld[$past(clr_idx)] && !data_vld[$past(clr_idx)]));
endmodule

// File: rtl/sq_load_port.sv
module sq_load_port
  import sq_idx_pkg::*;
#(
  parameter int IW = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [IW-1:0] req_idx,
  input  logic          req_delay,
  input  logic [IW-1:0] head,
  input  logic          idx_live,
  input  logic          ent_addr_vld,
  input  logic [AW-1:0] ent_addr,
  input  logic          ent_data_vld,
  input  logic [DW-1:0] ent_data,
  output logic [IW-1:0] rd_idx,
  output logic          ready,
  output logic          resp_valid,
  output logic          resp_fwd,
  output logic [DW-1:0] resp_data
);
  logic          busy;
  logic [AW-1:0] held_addr;
  logic [IW-1:0] held_idx;
  logic          held_delay;
  logic [AW-1:0] cur_addr;
  logic          cur_delay;
  lk_act_e       act;

  assign cur_addr  = busy ? held_addr  : req_addr;
  assign rd_idx    = busy ? held_idx   : req_idx;
  assign cur_delay = busy ? held_delay : req_delay;
  assign ready     = !busy;

  always_comb begin
    if (!(busy || req_valid))                           act = ACT_IDLE;
    else if (!idx_live)                                 act = ACT_CACHE;
    else if (cur_delay && head != rd_idx)               act = ACT_HOLD;
    else if (ent_addr_vld && ent_addr == cur_addr)      act = ent_data_vld ? ACT_FWD : ACT_HOLD;
    else                                                act = ACT_CACHE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      resp_valid <= 1'b0;
      resp_fwd   <= 1'b0;
      resp_data  <= '0;
      held_addr  <= '0;
      held_idx   <= '0;
      held_delay <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (act)
        ACT_HOLD: begin
          busy       <= 1'b1;
          held_addr  <= cur_addr;
          held_idx   <= rd_idx;
          held_delay <= cur_delay;
        end
        ACT_FWD: begin
          busy       <= 1'b0;
          resp_valid <= 1'b1;
          resp_fwd   <= 1'b1;
          resp_data  <= ent_data;
        end
        ACT_CACHE: begin
          busy       <= 1'b0;
          resp_valid <= 1'b1;
          resp_fwd   <= 1'b0;
          resp_data  <= '0;
        end
        default: ;
      endcase
    end
  end

  // R10: responses only follow an accepted or held load
  a_r10_resp_has_cause: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(busy || req_valid));
  // R3: forwarded data came from a slot with both address and data written
  a_r3_fwd_needs_data: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fwd) |-> $past(ent_addr_vld && ent_data_vld));
  // R5: a slot outside the live region sends the load to the cache
  a_r5_dead_slot_cache: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_IDLE && !idx_live) |=> (resp_valid && !resp_fwd));
  // R6: a held load produces no response and blocks new loads
  a_r6_hold_silent: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> (!resp_valid && !ready));
  // R7: a delayed load waits while its slot is live and not oldest
  a_r7_delay_waits: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_IDLE && cur_delay && idx_live && head != rd_idx) |=> !resp_valid);
endmodule

// File: rtl/sq_commit_check.sv
module sq_commit_check #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_valid,
  input  logic [DW-1:0] chk_used,
  input  logic [DW-1:0] chk_ref,
  output logic          flush
);
  always_ff @(posedge clk) begin
    if (rst) flush <= 1'b0;
    else     flush <= chk_valid && (chk_used != chk_ref);
  end

  // R8: a flush is always caused by a check in the cycle before
  a_r8_flush_has_check: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(chk_valid));
  // R8: a matching check stays quiet
  a_r8_match_quiet: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_used == chk_ref) |=> !flush);
endmodule

// File: rtl/sq_idx_fwd.sv
module sq_idx_fwd
  import sq_idx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_alloc,
  output logic [IW-1:0] st_alloc_idx,
  output logic          sq_full,
  input  logic          st_addr_we,
  input  logic [IW-1:0] st_addr_idx,
  input  logic [AW-1:0] st_addr,
  input  logic          st_data_we,
  input  logic [IW-1:0] st_data_idx,
  input  logic [DW-1:0] st_data,
  input  logic          st_commit,
  input  logic          ld_req_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [IW-1:0] ld_pred_idx,
  input  logic          ld_delay,
  output logic          ld_resp_valid,
  output logic          ld_resp_fwd,
  output logic [DW-1:0] ld_resp_data,
  input  logic          chk_valid,
  input  logic [DW-1:0] chk_used_data,
  input  logic [DW-1:0] chk_ref_data,
  output logic          flush
);
  logic [IW-1:0] head;
  logic [IW-1:0] tail;
  logic [CW-1:0] count;
  logic          alloc_ok;
  logic          commit_ok;
  logic [IW-1:0] rd_idx;
  logic [IW-1:0] rd_off;
  logic          idx_live;
  logic          ent_addr_vld;
  logic [AW-1:0] ent_addr;
  logic          ent_data_vld;
  logic [DW-1:0] ent_data;

  assign alloc_ok  = st_alloc && (count != CW'(DEPTH));
  assign commit_ok = st_commit && (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_ok)  tail <= tail + 1'b1;
      if (commit_ok) head <= head + 1'b1;
      case ({alloc_ok, commit_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assign st_alloc_idx = tail;
  assign sq_full      = (count == CW'(DEPTH));

  // slot is live when its distance from the head is below the occupancy
  assign rd_off   = rd_idx - head;
  assign idx_live = ({1'b0, rd_off} < count);

  sq_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_array (
    .clk         (clk),
    .rst         (rst),
    .clr_we      (alloc_ok),
    .clr_idx     (tail),
    .aw_we       (st_addr_we),
    .aw_idx      (st_addr_idx),
    .aw_addr     (st_addr),
    .dw_we       (st_data_we),
    .dw_idx      (st_data_idx),
    .dw_data     (st_data),
    .rd_idx      (rd_idx),
    .rd_addr_vld (ent_addr_vld),
    .rd_addr     (ent_addr),
    .rd_data_vld (ent_data_vld),
    .rd_data     (ent_data)
  );

  sq_load_port #(.IW(IW), .AW(AW), .DW(DW)) u_load (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (ld_req_valid),
    .req_addr     (ld_addr),
    .req_idx      (ld_pred_idx),
    .req_delay    (ld_delay),
    .head         (head),
    .idx_live     (idx_live),
    .ent_addr_vld (ent_addr_vld),
    .ent_addr     (ent_addr),
    .ent_data_vld (ent_data_vld),
    .ent_data     (ent_data),
    .rd_idx       (rd_idx),
    .ready        (ld_ready),
    .resp_valid   (ld_resp_valid),
    .resp_fwd     (ld_resp_fwd),
    .resp_data    (ld_resp_data)
  );

  sq_commit_check #(.DW(DW)) u_check (
    .clk       (clk),
    .rst       (rst),
    .chk_valid (chk_valid),
    .chk_used  (chk_used_data),
    .chk_ref   (chk_ref_data),
    .flush     (flush)
  );

  // R1: occupancy never passes the depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R1: a full queue refuses allocation
  a_r1_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (sq_full && st_alloc && !st_commit) |=> (sq_full && $stable(tail)));
  // R2: committing an empty queue changes nothing
  a_r2_empty_commit: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && st_commit && !st_alloc) |=> (count == '0 && $stable(head)));
endmodule

// File: tb/sq_idx_fwd_bench.sv
module sq_idx_fwd_bench;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          st_alloc = 1'b0;
  logic [IW-1:0] st_alloc_idx;
  logic          sq_full;
  logic          st_addr_we = 1'b0;
  logic [IW-1:0] st_addr_idx = '0;
  logic [AW-1:0] st_addr = '0;
  logic          st_data_we = 1'b0;
  logic [IW-1:0] st_data_idx = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_commit = 1'b0;
  logic          ld_req_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [IW-1:0] ld_pred_idx = '0;
  logic          ld_delay = 1'b0;
  logic          ld_resp_valid;
  logic          ld_resp_fwd;
  logic [DW-1:0] ld_resp_data;
  logic          chk_valid = 1'b0;
  logic [DW-1:0] chk_used_data = '0;
  logic [DW-1:0] chk_ref_data = '0;
  logic          flush;

  always #2.5 clk = ~clk;

  sq_idx_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sq_idx_fwd (
    .clk(clk), .rst(rst),
    .st_alloc(st_alloc), .st_alloc_idx(st_alloc_idx), .sq_full(sq_full),
    .st_addr_we(st_addr_we), .st_addr_idx(st_addr_idx), .st_addr(st_addr),
    .st_data_we(st_data_we), .st_data_idx(st_data_idx), .st_data(st_data),
    .st_commit(st_commit),
    .ld_req_valid(ld_req_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_pred_idx(ld_pred_idx), .ld_delay(ld_delay),
    .ld_resp_valid(ld_resp_valid), .ld_resp_fwd(ld_resp_fwd), .ld_resp_data(ld_resp_data),
    .chk_valid(chk_valid), .chk_used_data(chk_used_data), .chk_ref_data(chk_ref_data),
    .flush(flush)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model of the queue
  logic [AW-1:0] m_addr [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  logic          m_aval [DEPTH];
  logic          m_dval [DEPTH];
  logic [IW-1:0] m_head, m_tail;
  int            m_cnt;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cache_val(input logic [AW-1:0] a);
    return {16'hCAC0, a};
  endfunction

  // full associative search for the youngest live matching store
  function automatic logic [DW-1:0] ref_val(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = cache_val(a);
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] j;
      j = m_head + IW'(k);
      if (k < m_cnt && m_aval[j] && m_dval[j] && m_addr[j] == a) v = m_data[j];
    end
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_head = '0; m_tail = '0; m_cnt = 0;
    for (int k = 0; k < DEPTH; k++) begin
      m_aval[k] = 1'b0; m_dval[k] = 1'b0; m_addr[k] = '0; m_data[k] = '0;
    end
    @(negedge clk);
  endtask

  task automatic do_alloc();
    st_alloc = 1'b1;
    @(negedge clk);
    st_alloc = 1'b0;
    if (m_cnt < DEPTH) begin
      m_aval[m_tail] = 1'b0; m_dval[m_tail] = 1'b0;
      m_tail = m_tail + 1'b1; m_cnt++;
    end
  endtask

  task automatic do_commit();
    st_commit = 1'b1;
    @(negedge clk);
    st_commit = 1'b0;
    if (m_cnt > 0) begin
      m_head = m_head + 1'b1; m_cnt--;
    end
  endtask

  task automatic do_addr(input logic [IW-1:0] i, input logic [AW-1:0] a);
    st_addr_we = 1'b1; st_addr_idx = i; st_addr = a;
    @(negedge clk);
    st_addr_we = 1'b0;
    m_aval[i] = 1'b1; m_addr[i] = a;
  endtask

  task automatic do_data(input logic [IW-1:0] i, input logic [DW-1:0] d);
    st_data_we = 1'b1; st_data_idx = i; st_data = d;
    @(negedge clk);
    st_data_we = 1'b0;
    m_dval[i] = 1'b1; m_data[i] = d;
  endtask

  task automatic load_issue(input logic [AW-1:0] a, input logic [IW-1:0] i, input logic dly);
    check(ld_ready == 1'b1, "R10 ready before issue", DW'(ld_ready), 1);
    ld_req_valid = 1'b1; ld_addr = a; ld_pred_idx = i; ld_delay = dly;
    @(negedge clk);
    ld_req_valid = 1'b0; ld_delay = 1'b0;
  endtask

  task automatic load_finish(input logic [AW-1:0] a, input bit exp_fwd,
                             input logic [DW-1:0] exp_data, input string req);
    logic [DW-1:0] used, good;
    int n;
    n = 0;
    while (!ld_resp_valid && n < 6) begin
      @(negedge clk);
      n++;
    end
    check(ld_resp_valid == 1'b1, req, DW'(ld_resp_valid), 1);
    check(ld_resp_fwd == exp_fwd, req, DW'(ld_resp_fwd), DW'(exp_fwd));
    if (exp_fwd) check(ld_resp_data == exp_data, req, ld_resp_data, exp_data);
    used = ld_resp_fwd ? ld_resp_data : cache_val(a);
    good = ref_val(a);
    chk_valid = 1'b1; chk_used_data = used; chk_ref_data = good;
    @(negedge clk);
    chk_valid = 1'b0;
    check(ld_resp_valid == 1'b0, "R10 single-cycle response", DW'(ld_resp_valid), 0);
    check(flush == (used != good), "R8 flush on misforward", DW'(flush), DW'(used != good));
    @(negedge clk);
    check(flush == 1'b0, "R8 flush lasts one cycle", DW'(flush), 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(sq_full == 1'b0, "R9 reset full", DW'(sq_full), 0);
    check(st_alloc_idx == '0, "R9 reset tail", DW'(st_alloc_idx), 0);
    check(ld_ready == 1'b1, "R9 reset ready", DW'(ld_ready), 1);
    check(ld_resp_valid == 1'b0, "R9 reset resp", DW'(ld_resp_valid), 0);
    check(flush == 1'b0, "R9 reset flush", DW'(flush), 0);
  endtask

  task automatic t_fill_wrap();
    do_reset();
    for (int k = 0; k < DEPTH; k++) begin
      check(st_alloc_idx == IW'(k), "R1 alloc order", DW'(st_alloc_idx), DW'(k));
      do_alloc();
    end
    check(sq_full == 1'b1, "R1 full", DW'(sq_full), 1);
    do_alloc();
    check(st_alloc_idx == '0, "R1 alloc ignored when full", DW'(st_alloc_idx), 0);
    for (int k = 0; k < DEPTH; k++) do_commit();
    check(sq_full == 1'b0, "R2 drained", DW'(sq_full), 0);
    do_commit();
    do_alloc();
    check(st_alloc_idx == 2'd1, "R2 empty commit ignored", DW'(st_alloc_idx), 1);
    do_addr(2'd0, 16'h0A0A);
    do_data(2'd0, 32'h0000F00D);
    load_issue(16'h0A0A, 2'd0, 1'b0);
    load_finish(16'h0A0A, 1'b1, 32'h0000F00D, "R2 slot live after empty commit");
  endtask

  task automatic t_forward();
    do_reset();
    do_alloc(); do_alloc(); do_alloc();
    do_addr(2'd0, 16'h0100); do_data(2'd0, 32'h0000AAAA);
    do_addr(2'd1, 16'h0200); do_data(2'd1, 32'h0000BBBB);
    load_issue(16'h0200, 2'd1, 1'b0);
    load_finish(16'h0200, 1'b1, 32'h0000BBBB, "R3 forward matching slot");
    load_issue(16'h0100, 2'd0, 1'b0);
    load_finish(16'h0100, 1'b1, 32'h0000AAAA, "R3 forward older slot");
    load_issue(16'h0200, 2'd0, 1'b0);
    load_finish(16'h0200, 1'b0, '0, "R4 address mismatch goes to cache");
    load_issue(16'h0900, 2'd2, 1'b0);
    load_finish(16'h0900, 1'b0, '0, "R4 unwritten address goes to cache");
  endtask

  task automatic t_live();
    do_reset();
    do_alloc();
    do_addr(2'd0, 16'h0300); do_data(2'd0, 32'h00000011);
    do_commit();
    load_issue(16'h0300, 2'd0, 1'b0);
    load_finish(16'h0300, 1'b0, '0, "R5 committed slot is not live");
    load_issue(16'h0300, 2'd3, 1'b0);
    load_finish(16'h0300, 1'b0, '0, "R5 never allocated slot");
  endtask

  task automatic t_stall();
    do_reset();
    do_alloc();
    do_addr(2'd0, 16'h0400);
    load_issue(16'h0400, 2'd0, 1'b0);
    check(ld_resp_valid == 1'b0, "R6 no response without data", DW'(ld_resp_valid), 0);
    check(ld_ready == 1'b0, "R6 load held", DW'(ld_ready), 0);
    @(negedge clk); @(negedge clk);
    check(ld_resp_valid == 1'b0 && ld_ready == 1'b0, "R6 still held", DW'(ld_resp_valid), 0);
    do_data(2'd0, 32'h00000055);
    load_finish(16'h0400, 1'b1, 32'h00000055, "R6 forwards after data");
  endtask

  task automatic t_delay();
    do_reset();
    do_alloc(); do_alloc(); do_alloc();
    do_addr(2'd0, 16'h0500); do_data(2'd0, 32'h1);
    do_addr(2'd1, 16'h0500); do_data(2'd1, 32'h2);
    do_addr(2'd2, 16'h0500); do_data(2'd2, 32'h3);
    load_issue(16'h0500, 2'd2, 1'b1);
    check(ld_resp_valid == 1'b0, "R7 delayed load waits", DW'(ld_resp_valid), 0);
    do_commit();
    check(ld_resp_valid == 1'b0, "R7 waits for older stores", DW'(ld_resp_valid), 0);
    check(ld_ready == 1'b0, "R7 held while waiting", DW'(ld_ready), 0);
    do_commit();
    load_finish(16'h0500, 1'b1, 32'h3, "R7 forwards once slot is oldest");
  endtask

  task automatic t_misforward();
    do_reset();
    do_alloc(); do_alloc();
    do_addr(2'd0, 16'h0600); do_data(2'd0, 32'h00000066);
    do_addr(2'd1, 16'h0700); do_data(2'd1, 32'h00000077);
    load_issue(16'h0600, 2'd1, 1'b0);
    load_finish(16'h0600, 1'b0, '0, "R8 wrong slot prediction");
    chk_valid = 1'b1; chk_used_data = 32'h5; chk_ref_data = 32'h5;
    @(negedge clk);
    chk_valid = 1'b0;
    check(flush == 1'b0, "R8 match gives no flush", DW'(flush), 0);
  endtask

  initial begin
    t_reset();
    t_fill_wrap();
    t_forward();
    t_live();
    t_stall();
    t_delay();
    t_misforward();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule